// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block is the host-side driver for a 12-bit voltage-output converter with a parallel data bus. A host hands it a code and an I/O address through a valid/ready handshake. When the address matches the converter's slot, the block runs one write cycle on the converter pins. Chip-select goes low first, then write-enable pulses low while the data bus holds steady, and then both rise together. The wait between each pair of edges is a whole number of clock cycles. Each count is worked out from a nanosecond rule and the clock period, rounded up and never less than one.

The load strobe has three behaviours, chosen by a two-bit mode input. It can be held low all the time, so the converter output follows every write. It can pulse once after every write. It can stay high until a commit input asks for one pulse that moves a batch of writes to the output together.

A ramp source is built in. While it is enabled, a tick timer starts a write every `TICK_CYC` cycles, and the code goes up by one each time, so the output draws a sawtooth. A separate power-down pin follows a one-bit control register, and writes keep running while it is set.

Top module: `par_dac_wr_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the outputs are as follows. `dac_cs_n`, `dac_we_n`, `dac_ld_n` and `dac_pd_n` are 1, `dac_d` is 0, and `in_ready` is 1 when `ramp_en` is 0.
- R2: For an accepted write, `dac_cs_n` falls on the edge that accepts it, and `dac_d` takes the new code on that same edge. `dac_we_n` falls exactly N_CS cycles later, where N_CS = max(1, ceil(T_CS_WE_NS / CLK_NS)).
- R3: `dac_we_n` stays low for exactly N_DS = max(1, ceil(T_D_SU_NS / CLK_NS)) cycles. `dac_cs_n` and `dac_we_n` then rise on the same edge, and `dac_d` does not change from the fall of `dac_cs_n` until that edge.
- R4: `in_ready` is 0 from the edge where `dac_cs_n` falls until N_REC cycles after the rising write-enable edge. N_REC = max(N_WEH, N_LD), where N_WEH is the rounded-up count for T_WE_HI_NS and N_LD is the rounded-up count for T_LD_LO_NS. Write-enable therefore stays high for at least N_WEH cycles between pulses.
- R5: With `ld_mode` = 0 (transparent), `dac_ld_n` is 0 on every cycle after the first edge in that mode.
- R6: With `ld_mode` = 1 (pulse per write), `dac_ld_n` goes low on the same edge as the rising write-enable edge and stays low for N_REC cycles. It is 1 at all other times.
- R7: With `ld_mode` = 2 (batch), a write makes no load pulse. A cycle with `commit` = 1 causes one load pulse of N_LD cycles. The pulse starts once the sequencer is idle and takes priority over any waiting write, and `in_ready` is 0 while the pulse is waiting or running.
- R8: A request whose `in_addr` differs from `DAC_ADDR` still completes the handshake, but it drives no strobe and leaves `dac_d` unchanged.
- R9: While `ramp_en` is 1, `in_ready` is 0. One write starts for every `TICK_CYC` cycles, and the codes written are 0, 1, 2 and so on. The code wraps from 0xFFF to 0x000, so 4096 ticks make one period.
- R10: A cycle with `pd_wr` = 1 sets `dac_pd_n` to the inverse of `pd_on` on the next edge. Writes are sequenced the same way whatever the value of `dac_pd_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host request valid |
| in_ready | output | 1 | Sequencer can accept a host request |
| in_code | input | CODE_W | Code to write |
| in_addr | input | ADDR_W | I/O address of the request |
| ld_mode | input | 2 | 0 transparent, 1 pulse per write, 2 batch |
| commit | input | 1 | Requests one load pulse in batch mode |
| ramp_en | input | 1 | Enables the timer-driven sawtooth source |
| pd_wr | input | 1 | Writes the power-down control bit |
| pd_on | input | 1 | Value written: 1 requests power-down |
| dac_cs_n | output | 1 | Chip-select, active low |
| dac_we_n | output | 1 | Write-enable, active low |
| dac_d | output | CODE_W | Data bus to the converter |
| dac_ld_n | output | 1 | Load strobe, active low |
| dac_pd_n | output | 1 | Power-down pin, low requests power-down |

## Verification
The bench uses a 4 ns clock, which gives N_CS = 4 and N_DS = 3. T_LD_LO_NS is raised to 20 ns, so N_LD = 5 is larger than N_WEH = 3. This makes the recovery window visibly stretched by the load pulse instead of by the write-enable high time. `TICK_CYC` is cut to 16, so a full 4096-tick ramp period and its wrap from 0xFFF to 0x000 fit well within the run.

// File: rtl/par_dac_wr_pkg.sv
package par_dac_wr_pkg;

  typedef enum logic [1:0] {
    LD_TRANSP = 2'd0,
    LD_EACH   = 2'd1,
    LD_BATCH  = 2'd2
  } ld_mode_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CSU  = 3'd1,
    S_WLO  = 3'd2,
    S_REC  = 3'd3,
    S_LDP  = 3'd4
  } seq_state_e;

  // Round a nanosecond rule up to whole clock cycles, at least one.
  function automatic int cyc_of(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/par_dac_wr_tick.sv
module par_dac_wr_tick #(
  parameter int TICK_CYC = 51250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(TICK_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/par_dac_wr_ramp.sv
module par_dac_wr_ramp #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              take,
  output logic              pend,
  output logic [CODE_W-1:0] code
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      code <= '0;
    end else begin
      pend <= run && (tick || (pend && !take));
      if (take) code <= code + CODE_W'(1);
    end
  end

  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    take |-> pend);  // R9

endmodule

// File: rtl/par_dac_wr_fsm.sv
module par_dac_wr_fsm
  import par_dac_wr_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int N_CS   = 4,
  parameter int N_DS   = 3,
  parameter int N_WEH  = 3,
  parameter int N_LD   = 3,
  parameter int N_REC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              ld_go,
  input  ld_mode_e          mode,
  output logic              idle,
  output logic              cs_n,
  output logic              we_n,
  output logic              ld_n,
  output logic [CODE_W-1:0] dat
);
  localparam int MAXN = (N_CS > N_DS ? (N_CS > N_REC ? (N_CS > N_LD ? N_CS : N_LD)
                                                     : (N_REC > N_LD ? N_REC : N_LD))
                                     : (N_DS > N_REC ? (N_DS > N_LD ? N_DS : N_LD)
                                                     : (N_REC > N_LD ? N_REC : N_LD)));
  localparam int CW = $clog2(MAXN + 1);

  seq_state_e    st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    case (st)
      S_IDLE: begin
        if (wr_go) begin
          st_nx = S_CSU; cnt_nx = CW'(N_CS - 1);
        end else if (ld_go) begin
          st_nx = S_LDP; cnt_nx = CW'(N_LD - 1);
        end
      end
      S_CSU: begin
        if (cnt == '0) begin st_nx = S_WLO; cnt_nx = CW'(N_DS - 1); end
        else cnt_nx = cnt - CW'(1);
      end
      S_WLO: begin
        if (cnt == '0) begin st_nx = S_REC; cnt_nx = CW'(N_REC - 1); end
        else cnt_nx = cnt - CW'(1);
      end
      S_REC, S_LDP: begin
        if (cnt == '0) st_nx = S_IDLE;
        else cnt_nx = cnt - CW'(1);
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      cs_n <= 1'b1;
      we_n <= 1'b1;
      ld_n <= 1'b1;
      dat  <= '0;
    end else begin
      st   <= st_nx;
      cnt  <= cnt_nx;
      cs_n <= !(st_nx == S_CSU || st_nx == S_WLO);
      we_n <= !(st_nx == S_WLO);
      ld_n <= !(mode == LD_TRANSP || st_nx == S_LDP ||
                (st_nx == S_REC && mode == LD_EACH));
      if (st == S_IDLE && wr_go) dat <= wr_code;
    end
  end

  assign idle = (st == S_IDLE);

  // Checker counters: cycles spent low or high on each strobe.
  localparam int KW = $clog2(N_CS + N_DS + N_REC + N_WEH + 4) + 1;
  logic [KW-1:0] k_csl, k_wel, k_weh;

  always_ff @(posedge clk) begin
    if (rst) begin
      k_csl <= '0;
      k_wel <= '0;
      k_weh <= '1;
    end else begin
      k_csl <= cs_n  ? '0 : ((k_csl == '1) ? k_csl : k_csl + KW'(1));
      k_wel <= we_n  ? '0 : ((k_wel == '1) ? k_wel : k_wel + KW'(1));
      k_weh <= !we_n ? '0 : ((k_weh == '1) ? k_weh : k_weh + KW'(1));
    end
  end

  AST_CS_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> (!cs_n && k_csl >= KW'(N_CS)));  // R2
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (k_wel >= KW'(N_DS) && $rose(cs_n)));  // R3
  AST_DAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n)) |-> $stable(dat));  // R3
  AST_WE_RECOV: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> (k_weh >= KW'(N_WEH)));  // R4
  AST_LD_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
    ($fell(ld_n) && $past(mode) != LD_TRANSP) |-> we_n);  // R6
  AST_TRANSP_LD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == LD_TRANSP) |-> !ld_n);  // R5

endmodule

// File: rtl/par_dac_wr_seq.sv
module par_dac_wr_seq
  import par_dac_wr_pkg::*;
#(
  parameter int              CODE_W     = 12,
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] DAC_ADDR = 16'h0084,
  parameter int              CLK_NS     = 4,
  parameter int              T_CS_WE_NS = 13,
  parameter int              T_D_SU_NS  = 9,
  parameter int              T_WE_HI_NS = 10,
  parameter int              T_LD_LO_NS = 10,
  parameter int              TICK_CYC   = 51250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        ld_mode,
  input  logic              commit,
  input  logic              ramp_en,
  input  logic              pd_wr,
  input  logic              pd_on,
  output logic              dac_cs_n,
  output logic              dac_we_n,
  output logic [CODE_W-1:0] dac_d,
  output logic              dac_ld_n,
  output logic              dac_pd_n
);
  localparam int N_CS  = cyc_of(T_CS_WE_NS, CLK_NS);
  localparam int N_DS  = cyc_of(T_D_SU_NS, CLK_NS);
  localparam int N_WEH = cyc_of(T_WE_HI_NS, CLK_NS);
  localparam int N_LD  = cyc_of(T_LD_LO_NS, CLK_NS);
  localparam int N_REC = (N_WEH > N_LD) ? N_WEH : N_LD;

  ld_mode_e          mode;
  logic              idle, tick, ramp_pend, commit_pend;
  logic              host_fire, host_hit, ramp_go, ld_go, wr_go;
  logic [CODE_W-1:0] ramp_code, wr_code;

  assign mode      = ld_mode_e'(ld_mode);
  assign in_ready  = idle && !ramp_en && !commit_pend;
  assign host_fire = in_valid && in_ready;
  assign host_hit  = host_fire && (in_addr == DAC_ADDR);
  assign ld_go     = idle && commit_pend;
  assign ramp_go   = idle && !commit_pend && ramp_pend;
  assign wr_go     = host_hit || ramp_go;
  assign wr_code   = ramp_go ? ramp_code : in_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_pend <= 1'b0;
      dac_pd_n    <= 1'b1;
    end else begin
      commit_pend <= (mode == LD_BATCH) && (commit || (commit_pend && !ld_go));
      if (pd_wr) dac_pd_n <= !pd_on;
    end
  end

  par_dac_wr_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk(clk), .rst(rst), .run(ramp_en), .tick(tick)
  );

  par_dac_wr_ramp #(.CODE_W(CODE_W)) u_ramp (
    .clk(clk), .rst(rst), .run(ramp_en), .tick(tick),
    .take(ramp_go), .pend(ramp_pend), .code(ramp_code)
  );

  par_dac_wr_fsm #(
    .CODE_W(CODE_W), .N_CS(N_CS), .N_DS(N_DS), .N_WEH(N_WEH),
    .N_LD(N_LD), .N_REC(N_REC)
  ) u_fsm (
    .clk(clk), .rst(rst), .wr_go(wr_go), .wr_code(wr_code), .ld_go(ld_go),
    .mode(mode), .idle(idle), .cs_n(dac_cs_n), .we_n(dac_we_n),
    .ld_n(dac_ld_n), .dat(dac_d)
  );

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !dac_cs_n |-> !in_ready);  // R4
  AST_RAMP_BLOCKS_HOST: assert property (@(posedge clk) disable iff (rst)
    ramp_en |-> !in_ready);  // R9
  AST_MISS_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (host_fire && !host_hit && !ramp_go) |=> (dac_cs_n && $stable(dac_d)));  // R8
  AST_PD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    pd_wr |=> (dac_pd_n == !$past(pd_on)));  // R10
  AST_BATCH_NO_AUTO_LD: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == LD_BATCH && $rose(dac_we_n)) |-> dac_ld_n);  // R7

endmodule

// File: tb/par_dac_wr_seq_tb_top.sv
module par_dac_wr_seq_tb_top;
  localparam int TICK = 16;
  localparam int E_CS = 4;   // ceil(13/4)
  localparam int E_DS = 3;   // ceil(9/4)
  localparam int E_LD = 5;   // ceil(20/4)
  localparam int E_REC = 5;  // max(ceil(10/4), 5)
  localparam logic [15:0] HIT = 16'h0084;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, commit = 1'b0, ramp_en = 1'b0, pd_wr = 1'b0, pd_on = 1'b0;
  logic [11:0] in_code = '0;
  logic [15:0] in_addr = '0;
  logic [1:0]  ld_mode = 2'd0;
  logic        in_ready, dac_cs_n, dac_we_n, dac_ld_n, dac_pd_n;
  logic [11:0] dac_d;

  always #2 clk = ~clk;

  par_dac_wr_seq #(.T_LD_LO_NS(20), .TICK_CYC(TICK)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_addr(in_addr), .ld_mode(ld_mode), .commit(commit),
    .ramp_en(ramp_en), .pd_wr(pd_wr), .pd_on(pd_on), .dac_cs_n(dac_cs_n),
    .dac_we_n(dac_we_n), .dac_d(dac_d), .dac_ld_n(dac_ld_n), .dac_pd_n(dac_pd_n)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { bit cs; bit we; bit p; } frm_t;
  frm_t q[$];
  frm_t m_cur = '{1, 1, 0};
  bit   m_busy = 0, m_rpend = 0, m_cpend = 0, m_ld = 1, m_pd = 1, started = 0;
  int   m_tick = 0;
  logic [11:0] m_dat = '0, m_rcode = '0;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      q.delete(); m_busy = 0; m_cur = '{1, 1, 0}; m_rpend = 0; m_cpend = 0;
      m_ld = 1; m_pd = 1; m_tick = 0; m_dat = '0; m_rcode = '0;
    end else begin
      bit idle, rgo, hgo, lgo, hit;
      idle = !m_busy;
      lgo  = idle && m_cpend;
      rgo  = idle && !m_cpend && m_rpend;
      hgo  = idle && !ramp_en && !m_cpend && in_valid && (in_addr == HIT);
      if (rgo || hgo) begin
        for (int i = 0; i < E_CS; i++) q.push_back('{0, 1, 0});
        for (int i = 0; i < E_DS; i++) q.push_back('{0, 0, 0});
        for (int i = 0; i < E_REC; i++) q.push_back('{1, 1, ld_mode == 2'd1});
        m_dat = rgo ? m_rcode : in_code;
        if (rgo) m_rcode = m_rcode + 12'd1;
      end else if (lgo) begin
        for (int i = 0; i < E_LD; i++) q.push_back('{1, 1, 1});
      end
      hit     = ramp_en && (m_tick == TICK - 1);
      m_tick  = (!ramp_en || hit) ? 0 : m_tick + 1;
      m_rpend = ramp_en && (hit || (m_rpend && !rgo));
      m_cpend = (ld_mode == 2'd2) && (commit || (m_cpend && !lgo));
      if (pd_wr) m_pd = !pd_on;
      if (q.size() > 0) begin m_cur = q.pop_front(); m_busy = 1; end
      else begin m_cur = '{1, 1, 0}; m_busy = 0; end
      m_ld = !(ld_mode == 2'd0 || (m_busy && m_cur.p));
    end
  end

  // ---------------- per-cycle comparison and monitors ----------------
  logic [11:0] obs[$];
  int ld_falls = 0, we_rises = 0, csl = 0, wel = 0;
  logic p_we = 1, p_ld = 1;

  always begin
    @(negedge clk); #1;
    if (started && !done) begin
      string ldr;
      bit    e_rdy;
      ldr   = (ld_mode == 2'd0) ? "R5" : (ld_mode == 2'd1) ? "R6" : "R7";
      e_rdy = !m_busy && !ramp_en && !m_cpend;
      chk(dac_cs_n === m_cur.cs, "R2 cs_n", dac_cs_n, m_cur.cs);
      chk(dac_we_n === m_cur.we, "R3 we_n", dac_we_n, m_cur.we);
      chk(dac_d === m_dat, ramp_en ? "R9 data" : "R3 data", dac_d, m_dat);
      chk(in_ready === e_rdy, "R4 ready", in_ready, e_rdy);
      chk(dac_ld_n === m_ld, ldr, dac_ld_n, m_ld);
      chk(dac_pd_n === m_pd, "R10 pd_n", dac_pd_n, m_pd);
      if (!rst) begin
        if (p_we && !dac_we_n) chk(csl == E_CS, "R2 cs-to-we cycles", csl, E_CS);
        if (!p_we && dac_we_n) begin
          chk(wel == E_DS, "R3 we low cycles", wel, E_DS);
          obs.push_back(dac_d);
          we_rises++;
        end
        if (p_ld && !dac_ld_n) ld_falls++;
      end
      csl  = dac_cs_n ? 0 : csl + 1;
      wel  = dac_we_n ? 0 : wel + 1;
      p_we = dac_we_n;
      p_ld = dac_ld_n;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic host_wr(input logic [11:0] c, input logic [15:0] a);
    @(negedge clk);
    in_valid = 1; in_code = c; in_addr = a;
    forever begin
      #1;
      if (in_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base, f0, w0, bad;
    repeat (4) @(negedge clk);
    #1;
    // R1 during reset
    chk(dac_cs_n === 1'b1, "R1 cs_n", dac_cs_n, 1);
    chk(dac_we_n === 1'b1, "R1 we_n", dac_we_n, 1);
    chk(dac_ld_n === 1'b1, "R1 ld_n", dac_ld_n, 1);
    chk(dac_pd_n === 1'b1, "R1 pd_n", dac_pd_n, 1);
    chk(dac_d === 12'h000, "R1 data", dac_d, 0);
    chk(in_ready === 1'b1, "R1 ready", in_ready, 1);
    @(negedge clk); rst = 0;
    settle(3);

    // R5 transparent mode, back-to-back writes
    host_wr(12'h5A3, HIT);
    host_wr(12'hFFF, HIT);
    host_wr(12'h000, HIT);
    settle(16);
    chk(obs.size() == 3, "R5 write count", obs.size(), 3);
    if (obs.size() == 3) begin
      chk(obs[0] == 12'h5A3, "R5 code0", obs[0], 12'h5A3);
      chk(obs[1] == 12'hFFF, "R5 code1", obs[1], 12'hFFF);
      chk(obs[2] == 12'h000, "R5 code2", obs[2], 12'h000);
    end
    chk(ld_falls == 1 && dac_ld_n == 1'b0, "R5 ld held low", ld_falls, 1);

    // R6 pulse per write
    ld_mode = 2'd1; settle(3);
    f0 = ld_falls;
    host_wr(12'h123, HIT);
    host_wr(12'hABC, HIT);
    settle(16);
    chk(ld_falls - f0 == 2, "R6 one pulse per write", ld_falls - f0, 2);
    chk(obs[obs.size()-1] == 12'hABC, "R6 last code", obs[obs.size()-1], 12'hABC);

    // R8 address miss
    w0 = we_rises;
    host_wr(12'h777, 16'h0085);
    settle(16);
    chk(we_rises == w0, "R8 miss makes no write", we_rises, w0);
    chk(dac_d == 12'hABC, "R8 data unchanged", dac_d, 12'hABC);

    // R7 batch with commit
    ld_mode = 2'd2; settle(3);
    f0 = ld_falls;
    host_wr(12'h111, HIT);
    host_wr(12'h222, HIT);
    settle(16);
    chk(ld_falls == f0, "R7 no pulse before commit", ld_falls - f0, 0);
    @(negedge clk); commit = 1; @(negedge clk); commit = 0;
    settle(12);
    chk(ld_falls - f0 == 1, "R7 one pulse on commit", ld_falls - f0, 1);
    chk(dac_d == 12'h222, "R7 last data", dac_d, 12'h222);

    // R10 power-down control, writes continue
    @(negedge clk); pd_wr = 1; pd_on = 1; @(negedge clk); pd_wr = 0; #1;
    chk(dac_pd_n == 1'b0, "R10 pd_n low", dac_pd_n, 0);
    ld_mode = 2'd1;
    host_wr(12'h3C3, HIT);
    settle(16);
    chk(obs[obs.size()-1] == 12'h3C3, "R10 write during power-down", obs[obs.size()-1], 12'h3C3);
    @(negedge clk); pd_wr = 1; pd_on = 0; @(negedge clk); pd_wr = 0; #1;
    chk(dac_pd_n == 1'b1, "R10 pd_n high", dac_pd_n, 1);

    // R9 ramp over a full period and its wrap
    ld_mode = 2'd0; settle(3);
    base = obs.size();
    @(negedge clk); ramp_en = 1;
    settle(4096 * TICK + 40);
    ramp_en = 0;
    settle(20);
    chk(obs.size() - base >= 4097, "R9 ramp write count", obs.size() - base, 4097);
    if (obs.size() - base >= 4097) begin
      chk(obs[base] == 12'h000, "R9 first code", obs[base], 0);
      chk(obs[base + 4095] == 12'hFFF, "R9 top code", obs[base + 4095], 12'hFFF);
      chk(obs[base + 4096] == 12'h000, "R9 wrap code", obs[base + 4096], 0);
      bad = 0;
      for (int i = base + 1; i < obs.size(); i++)
        if (obs[i] != obs[i-1] + 12'd1) bad++;
      chk(bad == 0, "R9 step by one", bad, 0);
    end

    // host path works again after ramp
    host_wr(12'h456, HIT);
    settle(16);
    chk(obs[obs.size()-1] == 12'h456, "R4 host write after ramp", obs[obs.size()-1], 12'h456);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule